// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Sequencer

This block takes one operand transfer from a processor core (a byte, a word or a long word, read or write) and breaks it into as many bus cycles as the addressed device needs. It supports devices with an 8-bit port and devices with a 16-bit port. The device states its port width anew in every cycle through a two-bit active-low acknowledge. For each cycle the block drives a size code that gives the bytes still owed in the current piece, the byte address and the write data. Write bytes sit on the upper half, the lower half, or both halves of a 16-bit data bus.

After each acknowledge the block advances the address by the number of bytes that moved. For reads it keeps the bytes that were taken and drops the unused lane. It then either starts the next cycle or finishes. A long word at an odd address is run as two word-sized pieces, one after the other. Read bytes are collected most significant first into a right-justified 32-bit result, which is valid with a one-cycle done pulse.

Top module: `dbs_sequencer`

## Requirements
- R1: While busy, the size code gives the bytes still owed in the current piece: 1 → 2'b01, 2 → 2'b10, 3 → 2'b11, 4 → 2'b00.
- R2: An acknowledge of 2'b10 means an 8-bit port and 2'b01 means a 16-bit port. Values 2'b11 and 2'b00 leave the cycle pending, with address, size code and write data unchanged.
- R3: With an 8-bit port, exactly one byte moves per cycle, on data[15:8], and the address then rises by one.
- R4: With a 16-bit port at an odd address, one byte moves on data[7:0], and the address rises by one.
- R5: With a 16-bit port at an even address and at least two bytes owed in the piece, two bytes move: the earlier byte on data[15:8] and the later one on data[7:0]. The address rises by two.
- R6: A long word at an odd address runs as two 2-byte pieces, so its first cycle shows size code 2'b10. A long word at an even address is one 4-byte piece.
- R7: Write data carries the next operand byte on data[15:8]. On data[7:0] it carries that same byte when the address is odd or only one byte is owed in the piece, and the byte after it otherwise.
- R8: Read bytes are shifted into the result most significant first, so the result ends right-justified and zero-extended. The lane that carries no operand byte has no effect.
- R9: The clock edge that accepts the last acknowledge clears busy and raises done for exactly one cycle. The result is complete while done is high.
- R10: A request is taken only when idle, with reqSize 0 (byte), 1 (word) or 2 (long word). reqSize 3, and any request made while busy, are ignored.
- R11: After reset the block is idle, done is low and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transfer request strobe |
| reqSize | input | 2 | 0 byte, 1 word, 2 long word, 3 reserved |
| reqWrite | input | 1 | 1 write, 0 read |
| reqAddr | input | ADDR_W | Byte address of the operand |
| reqData | input | 32 | Write operand, right-justified |
| busy | output | 1 | Transfer in progress |
| busAddr | output | ADDR_W | Address of the current bus cycle |
| sizCode | output | 2 | Size code of the current cycle |
| busWrite | output | 1 | Direction of the current transfer |
| wrData | output | 16 | Write data lanes |
| rdData | input | 16 | Read data lanes |
| ackN | input | 2 | Active-low port-width acknowledge |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Assembled read operand |

## Verification
The bench steps through every operand size at even and odd addresses, answering with 8-bit, 16-bit and mixed port widths, both with and without wait cycles using either non-acknowledge code. Several faults would show up at once: treating an odd long word as one 4-byte piece would put 2'b00 or 2'b11 on the size code, and taking two bytes at an odd address would skip an address and misplace a result byte. A design that picked the wrong lower write lane for a one-byte remainder would send a stale byte. A design that reacted to 2'b00, or to a request made while busy, would move the address early or restart the transfer partway through.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int OPER_W = 32;
  localparam int LANE_W = 16;
  localparam int CNT_W  = 3;

  localparam logic [1:0] REQ_BYTE = 2'd0;
  localparam logic [1:0] REQ_WORD = 2'd1;
  localparam logic [1:0] REQ_LONG = 2'd2;
  localparam logic [1:0] REQ_RSVD = 2'd3;

  localparam logic [1:0] ACK_PORT8  = 2'b10;
  localparam logic [1:0] ACK_PORT16 = 2'b01;

  typedef struct packed {
    logic load;       // take a new request
    logic step;       // current bus cycle acknowledged
    logic twoBytes;   // this acknowledge moved two bytes
    logic loLane;     // single byte travelled on the lower lane
    logic lastInPiece;// one byte owed in the current piece
  } dbsStrobe_t;
endpackage

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
  import dbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic [1:0]       reqSize,
  input  logic             reqAddr0,
  input  logic             curAddr0,
  input  logic [1:0]       ackN,
  output logic             busy,
  output logic [1:0]       sizCode,
  output logic             done,
  output dbsStrobe_t       stb
);
  logic [CNT_W-1:0] totalRem, pieceRem, reqBytes, stepCnt, pieceNext, totalNext;
  logic acceptReq, ackByte, ackWord, acked, twoBytes;

  always_comb begin
    case (reqSize)
      REQ_BYTE: reqBytes = CNT_W'(1);
      REQ_WORD: reqBytes = CNT_W'(2);
      default:  reqBytes = CNT_W'(4);
    endcase
  end

  assign acceptReq = !busy && reqValid && (reqSize != REQ_RSVD);
  assign ackByte   = (ackN == ACK_PORT8);
  assign ackWord   = (ackN == ACK_PORT16);
  assign acked     = busy && (ackByte || ackWord);
  assign twoBytes  = ackWord && !curAddr0 && (pieceRem >= CNT_W'(2));
  assign stepCnt   = twoBytes ? CNT_W'(2) : CNT_W'(1);
  assign pieceNext = pieceRem - stepCnt;
  assign totalNext = totalRem - stepCnt;

  always_comb begin
    stb.load        = acceptReq;
    stb.step        = acked;
    stb.twoBytes    = twoBytes;
    stb.loLane      = ackWord && curAddr0;
    stb.lastInPiece = (pieceRem == CNT_W'(1));
  end

  always_comb begin
    case (pieceRem)
      CNT_W'(1): sizCode = 2'b01;
      CNT_W'(2): sizCode = 2'b10;
      CNT_W'(3): sizCode = 2'b11;
      default:   sizCode = 2'b00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      totalRem <= '0;
      pieceRem <= '0;
    end else begin
      done <= 1'b0;
      if (acceptReq) begin
        busy     <= 1'b1;
        totalRem <= reqBytes;
        pieceRem <= (reqSize == REQ_LONG && reqAddr0) ? CNT_W'(2) : reqBytes;
      end else if (acked) begin
        totalRem <= totalNext;
        if (pieceNext == '0) begin
          pieceRem <= totalNext;
          if (totalNext == '0) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          pieceRem <= pieceNext;
        end
      end
    end
  end

  // R2 / R10: without an acknowledge nothing advances and no request restarts
  a_r2_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !acked |=> busy && $stable(totalRem) && $stable(pieceRem));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r1_piece_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pieceRem != '0) && (pieceRem <= totalRem));
endmodule

// File: rtl/dbs_datapath.sv
module dbs_datapath
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dbsStrobe_t        stb,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [OPER_W-1:0] reqData,
  input  logic [LANE_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWrite,
  output logic [LANE_W-1:0] wrData,
  output logic [OPER_W-1:0] result
);
  localparam int BYTE_W = 8;
  logic [OPER_W-1:0] opReg, opInit;
  logic [BYTE_W-1:0] op0, op1, rdByte;

  always_comb begin
    case (reqSize)
      REQ_BYTE: opInit = {reqData[BYTE_W-1:0], {(OPER_W-BYTE_W){1'b0}}};
      REQ_WORD: opInit = {reqData[LANE_W-1:0], {(OPER_W-LANE_W){1'b0}}};
      default:  opInit = reqData;
    endcase
  end

  assign op0    = opReg[OPER_W-1 -: BYTE_W];
  assign op1    = opReg[OPER_W-BYTE_W-1 -: BYTE_W];
  assign wrData = {op0, (busAddr[0] || stb.lastInPiece) ? op0 : op1};
  assign rdByte = stb.loLane ? rdData[BYTE_W-1:0] : rdData[LANE_W-1:BYTE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busAddr  <= '0;
      busWrite <= 1'b0;
      opReg    <= '0;
      result   <= '0;
    end else if (stb.load) begin
      busAddr  <= reqAddr;
      busWrite <= reqWrite;
      opReg    <= opInit;
      result   <= '0;
    end else if (stb.step) begin
      if (stb.twoBytes) begin
        busAddr <= busAddr + ADDR_W'(2);
        opReg   <= opReg << LANE_W;
        if (!busWrite) result <= {result[OPER_W-LANE_W-1:0], rdData};
      end else begin
        busAddr <= busAddr + ADDR_W'(1);
        opReg   <= opReg << BYTE_W;
        if (!busWrite) result <= {result[OPER_W-BYTE_W-1:0], rdByte};
      end
    end
  end

  a_r5_pair_even: assert property (@(posedge clk) disable iff (!rst_n)
    stb.step && stb.twoBytes |-> !busAddr[0]);
  a_r4_low_lane_odd: assert property (@(posedge clk) disable iff (!rst_n)
    stb.step && stb.loLane |-> busAddr[0]);
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.step && !stb.load |=> $stable(busAddr) && $stable(opReg));
endmodule

// File: rtl/dbs_sequencer.sv
module dbs_sequencer
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqData,
  output logic              busy,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        sizCode,
  output logic              busWrite,
  output logic [15:0]       wrData,
  input  logic [15:0]       rdData,
  input  logic [1:0]        ackN,
  output logic              done,
  output logic [31:0]       result
);
  dbsStrobe_t stb;

  dbs_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqSize  (reqSize),
    .reqAddr0 (reqAddr[0]),
    .curAddr0 (busAddr[0]),
    .ackN     (ackN),
    .busy     (busy),
    .sizCode  (sizCode),
    .done     (done),
    .stb      (stb)
  );

  dbs_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .reqSize  (reqSize),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .rdData   (rdData),
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .wrData   (wrData),
    .result   (result)
  );
endmodule

// File: tb/tb_dbs_sequencer.sv
module tb_dbs_sequencer;
  localparam int AW = 24;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqSize = 2'd0, ackN = 2'b11;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0] reqData = '0;
  logic [15:0] rdData = '0;
  logic busy, busWrite, done;
  logic [AW-1:0] busAddr;
  logic [1:0] sizCode;
  logic [15:0] wrData;
  logic [31:0] result;
  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  dbs_sequencer #(.ADDR_W(AW)) dut (.*);

  // behavioural reference
  logic [7:0] mQ[$];
  logic [AW-1:0] mAddr;
  int mPiece = 0, mTotal = 0;
  logic mBusy = 0, mDone = 0, mWr = 0;
  logic [31:0] mResult = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mBusy = 0; mDone = 0; mResult = 0; mQ.delete();
    end else begin
      mDone = 0;
      if (!mBusy) begin
        if (reqValid && reqSize != 2'd3) begin
          int n;
          n = (reqSize == 0) ? 1 : (reqSize == 1) ? 2 : 4;
          mQ.delete();
          for (int i = n - 1; i >= 0; i--) mQ.push_back(reqData[8*i +: 8]);
          mAddr = reqAddr; mTotal = n; mWr = reqWrite; mResult = 0;
          mPiece = (n == 4 && reqAddr[0]) ? 2 : n;
          mBusy = 1;
        end
      end else if (ackN == 2'b10 || ackN == 2'b01) begin
        int k;
        k = (ackN == 2'b01 && !mAddr[0] && mPiece >= 2) ? 2 : 1;
        if (!mWr) begin
          if (k == 2) mResult = {mResult[15:0], rdData};
          else if (ackN == 2'b01 && mAddr[0]) mResult = {mResult[23:0], rdData[7:0]};
          else mResult = {mResult[23:0], rdData[15:8]};
        end
        for (int i = 0; i < k; i++) void'(mQ.pop_front());
        mAddr = mAddr + AW'(k); mPiece -= k; mTotal -= k;
        if (mPiece == 0) begin
          if (mTotal == 0) begin mBusy = 0; mDone = 1; end
          else mPiece = mTotal;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(busy === mBusy, "R10 busy", 32'(busy), 32'(mBusy));
      check(done === mDone, "R9 done", 32'(done), 32'(mDone));
      check(result === mResult, "R8 result", result, mResult);
      if (mBusy) begin
        logic [1:0] eSiz;
        logic [15:0] eWr;
        eSiz = (mPiece == 1) ? 2'b01 : (mPiece == 2) ? 2'b10 : (mPiece == 3) ? 2'b11 : 2'b00;
        check(sizCode === eSiz, "R1 sizCode", 32'(sizCode), 32'(eSiz));
        check(busAddr === mAddr, "R3/R4/R5 busAddr", 32'(busAddr), 32'(mAddr));
        if (mWr) begin
          eWr = {mQ[0], (mAddr[0] || mPiece == 1) ? mQ[0] : mQ[1]};
          check(wrData === eWr, "R7 wrData", 32'(wrData), 32'(eWr));
        end
      end
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // mode: 0 8-bit, 1 16-bit, 2 alternating; waits: insert non-acks
  task automatic runXfer(input logic [1:0] sz, input logic [AW-1:0] a, input bit wr,
                         input logic [31:0] d, input int mode, input bit waits, input bit junk);
    int cyc = 0;
    bit waited = 0;
    @(negedge clk);
    reqValid = 1; reqSize = sz; reqAddr = a; reqWrite = wr; reqData = d;
    @(negedge clk);
    if (sz == 2'd2) // R6
      check(sizCode === (a[0] ? 2'b10 : 2'b00), "R6 first size code", 32'(sizCode), a[0] ? 32'h2 : 32'h0);
    reqValid = junk; reqData = ~d; reqAddr = a + AW'(7); reqWrite = !wr; reqSize = 2'd0;
    while (busy) begin
      rdData = 16'($urandom);
      if (waits && !waited) begin
        logic [AW-1:0] held;
        held = busAddr;
        ackN = cyc[0] ? 2'b00 : 2'b11;
        waited = 1;
        @(negedge clk);
        check(busy === 1'b1 && busAddr === held, "R2 pending cycle holds", 32'(busAddr), 32'(held));
      end else begin
        ackN = (mode == 0 || (mode == 2 && cyc[0])) ? 2'b10 : 2'b01;
        cyc++; waited = 0;
        @(negedge clk);
      end
    end
    ackN = 2'b11; reqValid = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check(busy === 0 && done === 0 && result === 0, "R11 reset state", {busy, done, 30'(result)}, 32'h0);
    // R10 reserved size ignored
    reqValid = 1; reqSize = 2'd3; @(negedge clk); reqValid = 0;
    check(busy === 1'b0, "R10 reserved size ignored", 32'(busy), 32'h0);
    for (int sz = 0; sz < 3; sz++)
      for (int off = 0; off < 2; off++)
        for (int mode = 0; mode < 3; mode++)
          for (int wr = 0; wr < 2; wr++)
            runXfer(2'(sz), AW'(24'h1000 + off + 4 * mode), wr[0], $urandom,
                    mode, (sz + mode) % 2 == 1, wr == 1 && off == 1);
    // odd long word read, 16-bit port, with stray request while busy
    runXfer(2'd2, AW'(24'h2001), 1'b0, 32'h0, 1, 1'b1, 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule